// File: doc/BRIEF.md
# Register-File LIFO Stack with Wrap-Detected Flags

This block is a last-in-first-out store of 2**PTR_W words (64 by default) held in flip-flops. A pointer register names the entry that holds the current top item. Each push moves the pointer up by one and then writes the incoming word at the new position. Each pop copies the word at the pointer into a result register and then moves the pointer down by one. The pointer wraps at both ends. After reset it is zero, so the first stored word lands at entry 1 and the last word that fits lands at entry 0.

Both conditions, empty and full, leave the pointer at zero. The stack therefore keeps two flag registers to tell them apart, and the pointer width sets the capacity without a separate occupancy counter. Pushes enter through a valid/ready pair. Pops are plain one-cycle requests, answered one clock later by a single-cycle valid strobe with the result word. A request the stack cannot honour leaves every register unchanged and raises a one-cycle error pulse. Such requests are a push while full, a pop while empty, or a push and a pop in the same cycle.

Back-pressure rules: `push_ready` is the inverse of `full`. A push word is taken only in a cycle where `push_valid` and `push_ready` are both high and `pop_req` is low. Holding `push_valid` high while `push_ready` is low takes no word and signals an error in each such cycle.

Top module: `lifo_regstack`

## Requirements
- R1: While `rst_n` is low and after its release, `sp` is 0, `empty` is 1, `full` is 0, `err` is 0, `pop_valid` is 0 and `pop_data` is 0.
- R2: An accepted push raises `sp` by one, modulo 2**PTR_W, at the next clock. It stores `push_data` at the new `sp`, so `top_data` shows that word after the edge, and it clears `empty`.
- R3: The first push after reset leaves `sp` at 1. The 2**PTR_W-th push wraps `sp` to 0, stores its word at entry 0 and sets `full`.
- R4: An accepted pop puts the word at the old `sp` onto `pop_data` at the next clock, with `pop_valid` high, and lowers `sp` by one modulo 2**PTR_W.
- R5: A pop that brings `sp` to 0 sets `empty`. Every accepted pop clears `full`. `empty` is never high while `sp` is non-zero.
- R6: Popping the word held at entry 0 from a full stack leaves `sp` at 2**PTR_W-1, with both flags low.
- R7: `push_valid` while `full` is 1 takes no word. `sp`, the flags and the stored words are unchanged, and `err` is high for exactly the next cycle.
- R8: `pop_req` while `empty` is 1 changes nothing. `pop_valid` stays low, `pop_data` keeps its value and `err` pulses for one cycle.
- R9: `push_valid` and `pop_req` high in the same cycle count as an error. Nothing is stored or removed, `sp` is unchanged and `err` pulses.
- R10: `push_ready` equals the inverse of `full` in every cycle. Words come back out in the reverse of their push order.
- R11: `pop_valid` is high for one cycle per accepted pop and low in a cycle that follows an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push word offered |
| push_ready | output | 1 | Stack can take a word (not full) |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Pop request, one per cycle high |
| pop_valid | output | 1 | One-cycle strobe: `pop_data` holds a fresh popped word |
| pop_data | output | DATA_W | Result register of the last accepted pop |
| top_data | output | DATA_W | Word stored at the entry named by `sp` |
| sp | output | PTR_W | Stack pointer |
| full | output | 1 | Stack holds 2**PTR_W words |
| empty | output | 1 | Stack holds no words |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the stack with its default parameters, DATA_W of 8 and PTR_W of 6. At that size a run of 64 pushes fits in a short test, which makes the wrap of the pointer to zero on the last push and to 63 on the first pop from a full stack reachable. Eight-bit words are wide enough to give every one of the 64 entries a distinct value, so a word that lands in the wrong entry, or a pop order out of sequence, shows up as a wrong value.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

  // Decoded request class for one clock cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_BAD  = 2'd3
  } stk_op_e;

endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
(
  input  logic    push_valid,
  input  logic    pop_req,
  input  logic    full,
  input  logic    empty,
  output stk_op_e op
);

  logic both_req;
  logic push_blocked;
  logic pop_blocked;

  assign both_req     = push_valid & pop_req;
  assign push_blocked = push_valid & full;
  assign pop_blocked  = pop_req & empty;

  always_comb begin
    if (both_req || push_blocked || pop_blocked) begin
      op = OP_BAD;
    end else if (push_valid) begin
      op = OP_PUSH;
    end else if (pop_req) begin
      op = OP_POP;
    end else begin
      op = OP_IDLE;
    end
  end

endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr
  import lifo_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stk_op_e          op,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_up,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;

  logic [PTR_W-1:0] sp_dn;

  // Both neighbours wrap naturally in PTR_W bits
  assign sp_up = sp + PTR_ONE;
  assign sp_dn = sp - PTR_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= PTR_ZERO;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      unique case (op)
        OP_PUSH: begin
          sp    <= sp_up;
          full  <= (sp_up == PTR_ZERO);
          empty <= 1'b0;
        end
        OP_POP: begin
          sp    <= sp_dn;
          empty <= (sp_dn == PTR_ZERO);
          full  <= 1'b0;
        end
        default: begin
          sp    <= sp;
          full  <= full;
          empty <= empty;
        end
      endcase
    end
  end

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] entry_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_entry
      logic sel;
      assign sel = wr_en && (wr_addr == PTR_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          entry_q[g] <= '0;
        end else if (sel) begin
          entry_q[g] <= wr_data;
        end
      end
    end
  endgenerate

  assign rd_data = entry_q[rd_addr];

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
  import lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  output logic [DATA_W-1:0] top_data,
  output logic [PTR_W-1:0]  sp,
  output logic              full,
  output logic              empty,
  output logic              err
);

  stk_op_e          op;
  logic [PTR_W-1:0] sp_up;
  logic [DATA_W-1:0] rd_word;

  lifo_ctrl u_ctrl (
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .full       (full),
    .empty      (empty),
    .op         (op)
  );

  lifo_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .sp    (sp),
    .sp_up (sp_up),
    .full  (full),
    .empty (empty)
  );

  // Pre-increment: the write goes to the entry above the current top
  lifo_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op == OP_PUSH),
    .wr_addr (sp_up),
    .wr_data (push_data),
    .rd_addr (sp),
    .rd_data (rd_word)
  );

  assign top_data   = rd_word;
  assign push_ready = ~full;

  // Result register and strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_data  <= '0;
      pop_valid <= 1'b0;
      err       <= 1'b0;
    end else begin
      pop_valid <= (op == OP_POP);
      err       <= (op == OP_BAD);
      if (op == OP_POP) begin
        pop_data <= rd_word;
      end
    end
  end

endmodule

// File: rtl/lifo_regstack_chk.sv
module lifo_regstack_chk #(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             push_ready,
  input logic             pop_req,
  input logic             pop_valid,
  input logic [PTR_W-1:0] sp,
  input logic             full,
  input logic             empty,
  input logic             err
);

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !pop_req && !full) |=> (sp == PTR_W'($past(sp) + 1'b1)) && !empty); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_valid && !empty) |=> (sp == PTR_W'($past(sp) - 1'b1)) && pop_valid && !full); // R4

  AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (sp == '0)); // R5

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> err && $stable(sp) && full); // R7

  AST_EMPTY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty) |=> err && !pop_valid && $stable(sp)); // R8

  AST_BOTH_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop_req) |=> err && $stable(sp)); // R9

  AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ready == !full); // R10

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_req) |=> !pop_valid); // R11

endmodule

bind lifo_regstack lifo_regstack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_valid (push_valid),
  .push_ready (push_ready),
  .pop_req    (pop_req),
  .pop_valid  (pop_valid),
  .sp         (sp),
  .full       (full),
  .empty      (empty),
  .err        (err)
);

// File: tb/lifo_regstack_tb.sv
module lifo_regstack_tb;

  localparam int DATA_W = 8;
  localparam int PTR_W  = 6;
  localparam int DEPTH  = 1 << PTR_W;
  localparam int NVEC   = 10;

  // {push, pop, din[8], exp_sp[6], exp_full, exp_empty, exp_err, exp_pv, exp_pd[8]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00}, // R8 pop while empty
    {1'b1, 1'b0, 8'h11, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 first push -> 1
    {1'b1, 1'b0, 8'h22, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R2
    {1'b1, 1'b1, 8'h33, 6'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00}, // R9 both
    {1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22}, // R4
    {1'b0, 1'b0, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22}, // R11 idle
    {1'b1, 1'b0, 8'h44, 6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22}, // R2
    {1'b0, 1'b1, 8'h00, 6'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h44}, // R10 order
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11}, // R5 empty again
    {1'b0, 1'b1, 8'h00, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11}  // R8 keeps pop_data
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_valid = 1'b0;
  logic              push_ready;
  logic [DATA_W-1:0] push_data = '0;
  logic              pop_req = 1'b0;
  logic              pop_valid;
  logic [DATA_W-1:0] pop_data;
  logic [DATA_W-1:0] top_data;
  logic [PTR_W-1:0]  sp;
  logic              full;
  logic              empty;
  logic              err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  lifo_regstack #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_data  (push_data),
    .pop_req    (pop_req),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .top_data   (top_data),
    .sp         (sp),
    .full       (full),
    .empty      (empty),
    .err        (err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge act, return at the next falling edge
  task automatic do_op(input logic p, input logic q, input logic [DATA_W-1:0] d);
    push_valid = p;
    pop_req    = q;
    push_data  = d;
    @(posedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    pop_req    = 1'b0;
    push_data  = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [27:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sp", int'(sp), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 err", int'(err), 0);
    check("R1 pop_valid", int'(pop_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty after release", int'(empty), 1);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      do_op(v[27], v[26], v[25:18]);
      check($sformatf("vec%0d sp", i), int'(sp), int'(v[17:12]));
      check($sformatf("vec%0d full", i), int'(full), int'(v[11]));
      check($sformatf("vec%0d empty", i), int'(empty), int'(v[10]));
      check($sformatf("vec%0d err", i), int'(err), int'(v[9]));
      check($sformatf("vec%0d pop_valid", i), int'(pop_valid), int'(v[8]));
      check($sformatf("vec%0d pop_data", i), int'(pop_data), int'(v[7:0]));
    end

    // Fill to capacity: word k+1 at push k
    for (int k = 0; k < DEPTH; k++) begin
      do_op(1'b1, 1'b0, DATA_W'(k + 1));
      if (k == 0) check("R3 first push sp", int'(sp), 1);
      check("R2 top_data after push", int'(top_data), k + 1);
    end
    check("R3 wrap sp", int'(sp), 0);
    check("R3 full", int'(full), 1);
    check("R3 entry 0 word", int'(top_data), DEPTH);
    check("R10 ready low when full", int'(push_ready), 0);

    do_op(1'b1, 1'b0, 8'hEE);
    check("R7 err", int'(err), 1);
    check("R7 sp", int'(sp), 0);
    check("R7 full", int'(full), 1);
    check("R7 top unchanged", int'(top_data), DEPTH);
    do_op(1'b0, 1'b0, '0);
    check("R7 err one cycle", int'(err), 0);

    do_op(1'b0, 1'b1, '0);
    check("R6 sp", int'(sp), DEPTH - 1);
    check("R6 pop_data", int'(pop_data), DEPTH);
    check("R5 full cleared", int'(full), 0);
    check("R6 empty low", int'(empty), 0);
    check("R10 ready after pop", int'(push_ready), 1);
    do_op(1'b0, 1'b0, '0);
    check("R11 strobe drops", int'(pop_valid), 0);

    for (int k = DEPTH - 1; k >= 1; k--) begin
      do_op(1'b0, 1'b1, '0);
      check("R10 lifo order", int'(pop_data), k);
      check("R4 pop_valid", int'(pop_valid), 1);
    end
    check("R5 empty at end", int'(empty), 1);
    check("R5 sp at end", int'(sp), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule